// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a 1 KB direct-mapped data cache. It sits between a processor load/store port and a slower next-level memory. A byte address is split into three fields: a 22-bit tag, a 5-bit line index and a 5-bit byte offset. Each of the 32 lines holds eight 32-bit words. Every line stores one tag, one line-valid flag and one valid flag per word. A load hits when the indexed line is valid, its tag equals the address tag and the addressed word is valid. A hit returns the word in the same cycle.

A load miss fetches the line from memory as eight single-word read beats. Words that the line already holds are kept. Every store goes through to memory. A store that misses claims the line for its own tag without any fetch, and only the stored word is then valid. The processor presents a request and holds it until `cpu_stall` drops.

Top module: `dcache_wt`

## Requirements
- R1: After reset every line is invalid, `cpu_stall` and `mem_req` are low with no request, and the first load to any address misses.
- R2: Address bits 4:2 select the word, bits 9:5 the line and bits 31:10 the tag. A load hits only if the line is valid, all 22 tag bits match and the word is valid.
- R3: A load hit returns the word with `cpu_stall` low in the same cycle and raises no memory request.
- R4: A load miss issues eight read beats (`mem_we` low) at word addresses {tag, index, beat, 2'b00}, with the beat counting 0 to 7. `cpu_stall` stays high until the line is complete, and then the requested word is returned.
- R5: Every store issues exactly one memory write carrying the word-aligned address and the store data. `cpu_stall` equals the inverse of `mem_ready` while the store is pending.
- R6: A store that hits updates the cached word, and a later load of that word hits with the new value.
- R7: A store miss issues no read beat. It claims the line for the store's tag with only the stored word valid. A load of that word then hits, and a load of another word in the line misses.
- R8: A refill of a partly valid line keeps the words it already holds and writes only the invalid ones.
- R9: An access to an occupied index with a different tag replaces the line, so the earlier tag then misses.
- R10: A memory request that is not accepted (`mem_ready` low) is held with a stable address until `mem_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all valid flags |
| cpu_req | input | 1 | Processor access request, held until stall is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when request is high and stall low |
| cpu_stall | output | 1 | Processor must hold the request |
| mem_req | output | 1 | Next-level request |
| mem_we | output | 1 | 1 = write-through, 0 = refill read beat |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write-through data |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read beat |

## Verification
The hardest case to reach is a refill of a line that is only partly valid. A write-through leaves memory identical to the cache, so whether the refill kept a word or overwrote it cannot be seen at the ports. To make the difference visible, the bench first stores a word into a cold line, which claims the line without a fetch. It then changes its own memory model behind the cache for that word and loads a different word of the same line, which forces a refill. A final load of the stored word must return the stored value and not the changed one. A second bench mode inserts wait states on `mem_ready`, which exercises held beats and stalled write-throughs.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int ADDR_W     = 32;
  localparam int LINE_BYTES = 32;
  localparam int NUM_LINES  = 32;
  localparam int WORD_BYTES = 4;

  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int WPL    = LINE_BYTES / WORD_BYTES;
  localparam int WSEL_W = $clog2(WPL);
  localparam int BSEL_W = $clog2(WORD_BYTES);

  typedef enum logic [0:0] {ST_IDLE, ST_FILL} ctrl_state_t;

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] addr_word(input logic [ADDR_W-1:0] a);
    return a[BSEL_W +: WSEL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(WORD_BYTES - 1);
  endfunction

  function automatic logic [ADDR_W-1:0] beat_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic [WSEL_W-1:0] w);
    return {t, i, w, {BSEL_W{1'b0}}};
  endfunction

  function automatic logic [WPL-1:0] word_onehot(input logic [WSEL_W-1:0] w);
    logic [WPL-1:0] r;
    r = '0;
    r[w] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store
  import dcache_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_lv,
  output logic [WPL-1:0]   rd_wv,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [WPL-1:0]   wr_wv
);
  logic [TAG_W-1:0] tag_q [NUM_LINES];
  logic             lv_q  [NUM_LINES];
  logic [WPL-1:0]   wv_q  [NUM_LINES];

  assign rd_tag = tag_q[idx];
  assign rd_lv  = lv_q[idx];
  assign rd_wv  = wv_q[idx];

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[idx] <= wr_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        lv_q[i] <= 1'b0;
        wv_q[i] <= '0;
      end
    end else if (wr_en) begin
      lv_q[idx] <= 1'b1;
      wv_q[idx] <= wr_wv;
    end
  end
endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store
  import dcache_pkg::*;
(
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WSEL_W-1:0] word,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int DEPTH = NUM_LINES * WPL;
  logic [WORD_W-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[{idx, word}];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{idx, word}] <= wr_data;
  end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  line_idx,
  output logic [WSEL_W-1:0] line_word,
  input  logic [TAG_W-1:0]  meta_tag,
  input  logic              meta_lv,
  input  logic [WPL-1:0]    meta_wv,
  output logic              meta_we,
  output logic [TAG_W-1:0]  meta_wr_tag,
  output logic [WPL-1:0]    meta_wr_wv,
  output logic              data_we,
  output logic [WORD_W-1:0] data_wdata,
  output logic              fill_active
);
  ctrl_state_t       state_q;
  logic [IDX_W-1:0]  fill_idx_q;
  logic [TAG_W-1:0]  fill_tag_q;
  logic [WSEL_W-1:0] beat_q;
  logic              go_fill;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic              tag_match;
  logic              word_hit;
  logic              last_beat;

  assign req_tag     = addr_tag(cpu_addr);
  assign req_idx     = addr_idx(cpu_addr);
  assign req_word    = addr_word(cpu_addr);
  assign fill_active = (state_q == ST_FILL);
  assign last_beat   = (beat_q == WSEL_W'(WPL - 1));

  always_comb begin
    line_idx    = fill_active ? fill_idx_q : req_idx;
    line_word   = fill_active ? beat_q : req_word;
    tag_match   = meta_lv && (meta_tag == req_tag);
    word_hit    = tag_match && meta_wv[req_word];
    cpu_stall   = 1'b0;
    mem_req     = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = '0;
    mem_wdata   = '0;
    meta_we     = 1'b0;
    meta_wr_tag = req_tag;
    meta_wr_wv  = meta_wv;
    data_we     = 1'b0;
    data_wdata  = cpu_wdata;
    go_fill     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cpu_req && cpu_we) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = word_align(cpu_addr);
          mem_wdata = cpu_wdata;
          cpu_stall = !mem_ready;
          if (mem_ready) begin
            meta_we    = 1'b1;
            meta_wr_wv = (tag_match ? meta_wv : '0) | word_onehot(req_word);
            data_we    = 1'b1;
          end
        end else if (cpu_req && !word_hit) begin
          cpu_stall = 1'b1;
          go_fill   = 1'b1;
          if (!tag_match) begin
            meta_we    = 1'b1;
            meta_wr_wv = '0;
          end
        end
      end
      ST_FILL: begin
        cpu_stall   = 1'b1;
        mem_req     = 1'b1;
        mem_addr    = beat_addr(fill_tag_q, fill_idx_q, beat_q);
        meta_wr_tag = fill_tag_q;
        data_wdata  = mem_rdata;
        if (mem_ready && !meta_wv[beat_q]) begin
          meta_we    = 1'b1;
          meta_wr_wv = meta_wv | word_onehot(beat_q);
          data_we    = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fill_idx_q <= '0;
      fill_tag_q <= '0;
      beat_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (go_fill) begin
          state_q    <= ST_FILL;
          fill_idx_q <= req_idx;
          fill_tag_q <= req_tag;
          beat_q     <= '0;
        end
        ST_FILL: if (mem_ready) begin
          beat_q <= beat_q + 1'b1;
          if (last_beat) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt
  import dcache_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_stall,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata
);
  logic [IDX_W-1:0]  line_idx;
  logic [WSEL_W-1:0] line_word;
  logic [TAG_W-1:0]  meta_tag;
  logic              meta_lv;
  logic [WPL-1:0]    meta_wv;
  logic              meta_we;
  logic [TAG_W-1:0]  meta_wr_tag;
  logic [WPL-1:0]    meta_wr_wv;
  logic              data_we;
  logic [WORD_W-1:0] data_wdata;
  logic              fill_active;

  dcache_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_req     (cpu_req),
    .cpu_we      (cpu_we),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .cpu_stall   (cpu_stall),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready),
    .mem_rdata   (mem_rdata),
    .line_idx    (line_idx),
    .line_word   (line_word),
    .meta_tag    (meta_tag),
    .meta_lv     (meta_lv),
    .meta_wv     (meta_wv),
    .meta_we     (meta_we),
    .meta_wr_tag (meta_wr_tag),
    .meta_wr_wv  (meta_wr_wv),
    .data_we     (data_we),
    .data_wdata  (data_wdata),
    .fill_active (fill_active)
  );

  dcache_tag_store u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx    (line_idx),
    .rd_tag (meta_tag),
    .rd_lv  (meta_lv),
    .rd_wv  (meta_wv),
    .wr_en  (meta_we),
    .wr_tag (meta_wr_tag),
    .wr_wv  (meta_wr_wv)
  );

  dcache_data_store u_data (
    .clk     (clk),
    .idx     (line_idx),
    .word    (line_word),
    .rd_data (cpu_rdata),
    .wr_en   (data_we),
    .wr_data (data_wdata)
  );
endmodule

// File: rtl/dcache_wt_chk.sv
module dcache_wt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_stall,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic        fill_active
);
  a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && !cpu_stall) |-> !mem_req);

  a_r4_read_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (cpu_stall && fill_active));

  a_r4_beats_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready && mem_addr[4:2] != 3'd7) |=>
    (mem_req && !mem_we && mem_addr[4:2] == 3'($past(mem_addr[4:2]) + 3'd1)));

  a_r5_store_through: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !fill_active) |->
    (mem_req && mem_we && mem_addr[1:0] == 2'b00 && cpu_stall == !mem_ready));

  a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && !fill_active) |-> (!mem_req && !cpu_stall));
endmodule

bind dcache_wt dcache_wt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_req     (cpu_req),
  .cpu_we      (cpu_we),
  .cpu_stall   (cpu_stall),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_ready   (mem_ready),
  .mem_addr    (mem_addr),
  .fill_active (fill_active)
);

// File: tb/dcache_wt_tb.sv
`timescale 1ns/1ps
module dcache_wt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_rdata;

  int total = 0, bad = 0;
  int rdy_mode = 0, cyc = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_log [16];
  logic [31:0] model [4096];

  always #4 clk = ~clk;

  dcache_wt u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = model[mem_addr[13:2]];

  always @(negedge clk) begin
    cyc++;
    mem_ready = (rdy_mode == 0) || (cyc % 3 == 0);
  end

  always @(negedge clk) begin
    #3;
    if (rst_n && mem_req && mem_ready) begin
      if (mem_we) begin
        model[mem_addr[13:2]] = mem_wdata;
        wr_cnt++;
      end else begin
        if (rd_cnt < 16) rd_log[rd_cnt] = mem_addr;
        rd_cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int stalls);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    stalls = 0; rd_cnt = 0; wr_cnt = 0; rd = '0;
    forever begin
      #2;
      if (!cpu_stall) begin
        rd = cpu_rdata;
        break;
      end
      stalls++;
      if (stalls > 500) begin
        chk("watchdog", 32'(stalls), 32'd0);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic check_fill(input string req, input logic [31:0] a);
    chk({req, " beat count"}, 32'(rd_cnt), 32'd8);
    for (int k = 0; k < 8; k++)
      chk({req, " beat order"}, rd_log[k], {a[31:5], 3'(k), 2'b00});
  endtask

  task automatic t_reset;
    logic [31:0] rd; int st;
    #2;
    chk("R1 stall idle", 32'(cpu_stall), 32'd0);
    chk("R1 mem_req idle", 32'(mem_req), 32'd0);
    access(1'b0, 32'h0000_0048, '0, rd, st);
    chk("R1 cold load misses", 32'(st > 0), 32'd1);
    chk("R4 miss data", rd, model[12'h012]);
    check_fill("R4", 32'h0000_0048);
  endtask

  task automatic t_hit;
    logic [31:0] rd; int st;
    access(1'b0, 32'h0000_0054, '0, rd, st);
    chk("R3 hit no stall", 32'(st), 32'd0);
    chk("R3 hit no beats", 32'(rd_cnt + wr_cnt), 32'd0);
    chk("R3 hit data", rd, model[12'h015]);
  endtask

  task automatic t_store_hit;
    logic [31:0] rd; int st;
    access(1'b1, 32'h0000_0046, 32'hDEAD_BEEF, rd, st);
    chk("R5 one write", 32'(wr_cnt), 32'd1);
    chk("R5 no read", 32'(rd_cnt), 32'd0);
    chk("R5 memory updated", model[12'h011], 32'hDEAD_BEEF);
    access(1'b0, 32'h0000_0044, '0, rd, st);
    chk("R6 store hit then load hits", 32'(st), 32'd0);
    chk("R6 new value", rd, 32'hDEAD_BEEF);
  endtask

  task automatic t_store_miss;
    logic [31:0] rd; int st;
    access(1'b1, 32'h0000_0C64, 32'h1234_5678, rd, st);
    chk("R7 no fetch on store miss", 32'(rd_cnt), 32'd0);
    chk("R7 write through", 32'(wr_cnt), 32'd1);
    access(1'b0, 32'h0000_0C64, '0, rd, st);
    chk("R7 stored word hits", 32'(st), 32'd0);
    chk("R7 stored word value", rd, 32'h1234_5678);
    model[12'h319] = 32'hBAD0_BAD0;
    access(1'b0, 32'h0000_0C68, '0, rd, st);
    chk("R7 other word misses", 32'(st > 0), 32'd1);
    chk("R8 refill data", rd, model[12'h31A]);
    check_fill("R8", 32'h0000_0C68);
    access(1'b0, 32'h0000_0C64, '0, rd, st);
    chk("R8 kept word hits", 32'(st), 32'd0);
    chk("R8 kept word value", rd, 32'h1234_5678);
  endtask

  task automatic t_conflict;
    logic [31:0] rd; int st;
    access(1'b0, 32'h0000_0444, '0, rd, st);
    chk("R9 new tag misses", 32'(st > 0), 32'd1);
    chk("R9 new tag data", rd, model[12'h111]);
    access(1'b0, 32'h0000_0044, '0, rd, st);
    chk("R9 evicted tag misses", 32'(st > 0), 32'd1);
    chk("R9 refetched write-through value", rd, 32'hDEAD_BEEF);
    access(1'b0, 32'h8000_0044, '0, rd, st);
    chk("R2 top tag bit compared", 32'(st > 0), 32'd1);
    access(1'b0, 32'h8000_0048, '0, rd, st);
    chk("R2 same line now hits", 32'(st), 32'd0);
    chk("R2 hit data", rd, model[12'h012]);
  endtask

  task automatic t_slow;
    logic [31:0] rd; int st;
    rdy_mode = 1;
    access(1'b0, 32'h0000_020C, '0, rd, st);
    chk("R10 slow refill data", rd, model[12'h083]);
    chk("R10 slow refill long", 32'(st >= 16), 32'd1);
    check_fill("R10", 32'h0000_020C);
    access(1'b1, 32'h0000_0200, 32'hCAFE_0001, rd, st);
    chk("R5 slow store one write", 32'(wr_cnt), 32'd1);
    chk("R5 slow store memory", model[12'h080], 32'hCAFE_0001);
    rdy_mode = 0;
    access(1'b0, 32'h0000_0200, '0, rd, st);
    chk("R6 slow store cached", rd, 32'hCAFE_0001);
    chk("R6 slow store hit", 32'(st), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) model[i] = {16'hA5C3 ^ 16'(i * 7), 16'(i)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hit();
    t_store_hit();
    t_store_miss();
    t_conflict();
    t_slow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule